// File: doc/BRIEF.md
# Aligned Pulse-Width Modulator Channel

This block drives one pulse-width modulated output. A counter moves one step on each cycle where the external clock-enable input is high. Its sweep pattern depends on the alignment mode. In left-aligned mode the counter ramps up and wraps, which gives a sawtooth. In center-aligned mode the counter climbs and then descends, which gives a symmetric triangle, so a center-aligned period lasts twice as many steps as a left-aligned period with the same setting. The output is found by comparing the counter with a threshold derived from the duty value, and a polarity bit then selects which level is the active one.

The configuration arrives on plain parallel inputs. Period, duty and alignment are captured into working copies. These copies follow the inputs freely while the channel is off. While the channel runs, they are refreshed only when a period completes, so a reconfiguration never produces a partial period. Polarity is captured only while the channel is off. When the channel is off, the output shows the polarity input directly. A one-cycle strobe marks each completed period.

Top module: `pwm_aligned_gen`

## Requirements
- R1: In left-aligned mode (centerMode = 0) with a working period P >= 1, the counter takes the values 0, 1, ..., P-1 on successive enabled ticks and then returns to 0, so one period lasts P ticks.
- R2: In center-aligned mode (centerMode = 1) with P >= 1, the counter rises 0..P-1 and then falls P-1..0, with each turning value held for two ticks, so one period lasts 2P ticks. With P = 0, in either mode, the counter stays at 0 and every tick ends a period.
- R3: While enabled, pwmOut equals the latched polarity when counter >= P - min(D, P), and equals its inverse otherwise. Here D is the working duty.
- R4: With D = 0 and P >= 1 the output stays at the inverse of polarity for the whole run. With D >= P it stays at the polarity level. These constant levels hold in both modes.
- R5: While enable is low, pwmOut equals the polarity input in the same cycle. While enable is high, changes on the polarity input have no effect on pwmOut.
- R6: While enable is low, the counter is held at 0 and periodEnd stays low. After enable rises, the sweep starts at counter value 0.
- R7: The counter, and therefore the output pattern, advances only at clock edges where tick is high.
- R8: New periodIn, dutyIn and centerMode values that arrive while the channel is enabled take effect only from the start of the next period.
- R9: periodEnd is high for exactly one cycle: the cycle after the tick edge that completes a period.
- R10: rst is synchronous and active high. It clears the counter, the working registers and the latched polarity, and holds periodEnd low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Counter step enable |
| enable | input | 1 | Channel run control |
| centerMode | input | 1 | 0 = left aligned, 1 = center aligned |
| polarity | input | 1 | Active output level |
| periodIn | input | W | Period setting |
| dutyIn | input | W | Duty setting |
| pwmOut | output | 1 | Waveform output |
| periodEnd | output | 1 | One-cycle period completion strobe |

## Verification
The bench sweeps every period from 0 to 6 against duties from 0 up to one past the period, in both modes and with both polarities. Over each run it compares the output and the strobe with arithmetic expectations. An off-by-one threshold would show up as a one-tick glitch in the duty 0 or full-duty runs, and a wrong turning-point dwell would break the 2P period of the center-aligned runs. Further runs do the following:

- change period, duty and mode partway through a period, which a design without shadow registers would apply at once and so cut the current period short;
- toggle polarity while the channel runs, which a design that does not latch polarity would show immediately;
- gate the tick input, which would expose a counter that advances on idle cycles;
- stop the channel mid-sweep, which checks that the sweep restarts from zero.

// File: rtl/pwm_align_pkg.sv
package pwm_align_pkg;

  typedef enum logic {
    ALIGN_LEFT   = 1'b0,
    ALIGN_CENTER = 1'b1
  } alignMode_t;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } countDir_t;

  // Strobes from the sweep control to the compare datapath.
  typedef struct packed {
    logic loadShadow;  // refresh period, duty and mode working copies
    logic latchPol;    // capture polarity (channel idle)
    logic advance;     // counter stepped this cycle
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_align_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] period,
  input  logic [W-1:0] duty,
  input  logic         activeLevel,
  output logic         level
);

  logic [W-1:0] effDuty;
  logic [W-1:0] threshold;

  // Duty beyond the period saturates to a full-on waveform.
  always_comb begin
    effDuty   = (duty > period) ? period : duty;
    threshold = period - effDuty;
    level     = (count >= threshold) ? activeLevel : ~activeLevel;
  end

endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_align_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         enable,
  input  logic [W-1:0] curPeriod,
  input  alignMode_t   curMode,
  output pwmStrobe_t   strobe,
  output logic [W-1:0] count,
  output logic         periodEnd
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  countDir_t    dir;
  countDir_t    nextDir;
  logic [W-1:0] nextCount;
  logic         zeroPeriod;
  logic         atTop;
  logic         wrap;

  assign zeroPeriod = (curPeriod == ZERO);
  assign atTop      = zeroPeriod || (count == curPeriod - ONE);

  // Detect the tick that completes the current period.
  always_comb begin
    if (zeroPeriod) begin
      wrap = 1'b1;
    end else if (curMode == ALIGN_LEFT) begin
      wrap = atTop;
    end else begin
      wrap = (dir == DIR_DOWN) && (count == ZERO);
    end
  end

  always_comb begin
    strobe.advance    = enable && tick;
    strobe.latchPol   = !enable;
    strobe.loadShadow = !enable || (tick && wrap);
  end

  // Next counter position and direction.
  always_comb begin
    nextCount = count;
    nextDir   = dir;
    if (!enable) begin
      nextCount = ZERO;
      nextDir   = DIR_UP;
    end else if (tick) begin
      if (zeroPeriod) begin
        nextCount = ZERO;
        nextDir   = DIR_UP;
      end else if (curMode == ALIGN_LEFT) begin
        nextCount = atTop ? ZERO : count + ONE;
        nextDir   = DIR_UP;
      end else if (dir == DIR_UP) begin
        if (atTop) begin
          nextDir = DIR_DOWN;       // dwell once at the top
        end else begin
          nextCount = count + ONE;
        end
      end else begin
        if (count == ZERO) begin
          nextDir = DIR_UP;         // dwell once at the bottom, period ends
        end else begin
          nextCount = count - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= ZERO;
      dir       <= DIR_UP;
      periodEnd <= 1'b0;
    end else begin
      count     <= nextCount;
      dir       <= nextDir;
      periodEnd <= enable && tick && wrap;
    end
  end

  // R1: left sweep stays below the period
  p_left_range_r1: assert property (@(posedge clk) disable iff (rst)
    (enable && curMode == ALIGN_LEFT && !zeroPeriod) |-> (count < curPeriod));

  // R2: center sweep stays below the period
  p_center_range_r2: assert property (@(posedge clk) disable iff (rst)
    (enable && curMode == ALIGN_CENTER && !zeroPeriod) |-> (count < curPeriod));

  // R6: idle channel parks the counter and raises no strobe
  p_idle_park_r6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (count == ZERO && !periodEnd));

  // R7: no tick, no movement
  p_tick_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (enable && !tick) |=> $stable(count));

  // R9: a completed period always restarts at zero
  p_end_at_zero_r9: assert property (@(posedge clk) disable iff (rst)
    periodEnd |-> (count == ZERO));

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_align_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  pwmStrobe_t   strobe,
  input  logic [W-1:0] count,
  input  logic [W-1:0] periodIn,
  input  logic [W-1:0] dutyIn,
  input  logic         centerMode,
  input  logic         polarity,
  output logic [W-1:0] curPeriod,
  output alignMode_t   curMode,
  output logic         pwmOut
);

  logic [W-1:0] curDuty;
  logic         polReg;
  logic         cmpLevel;

  always_ff @(posedge clk) begin
    if (rst) begin
      curPeriod <= '0;
      curDuty   <= '0;
      curMode   <= ALIGN_LEFT;
    end else if (strobe.loadShadow) begin
      curPeriod <= periodIn;
      curDuty   <= dutyIn;
      curMode   <= alignMode_t'(centerMode);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      polReg <= 1'b0;
    end else if (strobe.latchPol) begin
      polReg <= polarity;
    end
  end

  pwm_compare #(.W(W)) u_compare (
    .count       (count),
    .period      (curPeriod),
    .duty        (curDuty),
    .activeLevel (polReg),
    .level       (cmpLevel)
  );

  // Idle channel shows the polarity input without waiting for a clock.
  assign pwmOut = enable ? cmpLevel : polarity;

  // R4: full duty gives a constant active level
  p_full_duty_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && curDuty >= curPeriod) |-> (pwmOut == polReg));

  // R4: zero duty gives a constant inactive level
  p_zero_duty_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && curDuty == '0 && curPeriod != '0) |-> (pwmOut == ~polReg));

  // R5: polarity frozen while running
  p_pol_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    enable |=> (polReg == $past(polReg)));

endmodule

// File: rtl/pwm_aligned_gen.sv
module pwm_aligned_gen
  import pwm_align_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         enable,
  input  logic         centerMode,
  input  logic         polarity,
  input  logic [W-1:0] periodIn,
  input  logic [W-1:0] dutyIn,
  output logic         pwmOut,
  output logic         periodEnd
);

  pwmStrobe_t   strobe;
  logic [W-1:0] count;
  logic [W-1:0] curPeriod;
  alignMode_t   curMode;

  pwm_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .enable    (enable),
    .curPeriod (curPeriod),
    .curMode   (curMode),
    .strobe    (strobe),
    .count     (count),
    .periodEnd (periodEnd)
  );

  pwm_datapath #(.W(W)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .strobe     (strobe),
    .count      (count),
    .periodIn   (periodIn),
    .dutyIn     (dutyIn),
    .centerMode (centerMode),
    .polarity   (polarity),
    .curPeriod  (curPeriod),
    .curMode    (curMode),
    .pwmOut     (pwmOut)
  );

endmodule

// File: tb/test_pwm_aligned_gen.sv
`timescale 1ns/1ps
module test_pwm_aligned_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       enable = 1'b0;
  logic       centerMode = 1'b0;
  logic       polarity = 1'b0;
  logic [7:0] periodIn = '0;
  logic [7:0] dutyIn = '0;
  logic       pwmOut;
  logic       periodEnd;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  pwm_aligned_gen #(.W(8)) i_pwm_aligned_gen (
    .clk(clk), .rst(rst), .tick(tick), .enable(enable),
    .centerMode(centerMode), .polarity(polarity),
    .periodIn(periodIn), .dutyIn(dutyIn),
    .pwmOut(pwmOut), .periodEnd(periodEnd)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int periodLen(int p, bit ctr);
    if (p == 0) return 1;
    return ctr ? 2 * p : p;
  endfunction

  // Expected output at step k of a period.
  function automatic logic expLevel(int p, int d, bit ctr, bit pol, int k);
    int c;
    int effD;
    if (p == 0) return pol;
    c    = (ctr && k >= p) ? (2 * p - 1 - k) : k;
    effD = (d > p) ? p : d;
    return (c >= p - effD) ? pol : ~pol;
  endfunction

  function automatic string tagFor(int p, int d, bit ctr);
    if (d == 0 || d >= p) return "R4";
    return ctr ? "R2 R3" : "R1 R3";
  endfunction

  task automatic runCase(int p, int d, bit ctr, bit pol);
    int len;
    len = periodLen(p, ctr);
    @(negedge clk);
    enable = 1'b0; tick = 1'b0;
    periodIn = 8'(p); dutyIn = 8'(d); centerMode = ctr; polarity = pol;
    @(negedge clk);
    #1 chk("R6 idle level", pwmOut, pol);
    enable = 1'b1; tick = 1'b1;
    for (int i = 0; i < 2 * len + 1; i++) begin
      #1;
      chk(tagFor(p, d, ctr), pwmOut, expLevel(p, d, ctr, pol, i % len));
      chk("R9 strobe", periodEnd, (i > 0) && (i % len == 0));
      @(negedge clk);
    end
    enable = 1'b0; tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ticksDone;
    bit prevTick;
    // R10: reset state
    repeat (3) @(negedge clk);
    #1 chk("R10 reset strobe", periodEnd, 1'b0);
    chk("R10 reset level", pwmOut, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1 chk("R10 strobe after reset", periodEnd, 1'b0);

    // R5: idle channel follows polarity in the same cycle
    @(negedge clk);
    polarity = 1'b1;
    #1 chk("R5 idle follow high", pwmOut, 1'b1);
    @(negedge clk);
    polarity = 1'b0;
    #1 chk("R5 idle follow low", pwmOut, 1'b0);

    // Sweep: R1 R2 R3 R4 R9
    for (int p = 0; p <= 6; p++)
      for (int d = 0; d <= p + 1; d++)
        for (int m = 0; m < 2; m++)
          for (int q = 0; q < 2; q++)
            runCase(p, d, m[0], q[0]);

    // R5: polarity changes ignored while enabled
    @(negedge clk);
    periodIn = 8'd4; dutyIn = 8'd1; centerMode = 1'b0; polarity = 1'b0;
    @(negedge clk);
    enable = 1'b1; tick = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (i == 2) polarity = 1'b1;
      #1 chk("R5 polarity frozen", pwmOut, expLevel(4, 1, 1'b0, 1'b0, i % 4));
      @(negedge clk);
    end
    enable = 1'b0; tick = 1'b0; polarity = 1'b0;

    // R8: mid-period reconfiguration applies at the period end
    @(negedge clk);
    periodIn = 8'd4; dutyIn = 8'd1; centerMode = 1'b0;
    @(negedge clk);
    enable = 1'b1; tick = 1'b1;
    for (int i = 0; i < 18; i++) begin
      if (i == 2) begin periodIn = 8'd6; dutyIn = 8'd3; centerMode = 1'b1; end
      #1;
      if (i < 4) chk("R8 old settings kept", pwmOut, expLevel(4, 1, 1'b0, 1'b0, i));
      else       chk("R8 new settings used", pwmOut, expLevel(6, 3, 1'b1, 1'b0, (i - 4) % 12));
      chk("R8 strobe", periodEnd, (i == 4) || (i == 16));
      @(negedge clk);
    end
    enable = 1'b0; tick = 1'b0;

    // R7: gated ticks
    @(negedge clk);
    periodIn = 8'd4; dutyIn = 8'd2; centerMode = 1'b0; polarity = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    ticksDone = 0; prevTick = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tick = (i % 3 == 0);
      #1;
      chk("R7 gated level", pwmOut, expLevel(4, 2, 1'b0, 1'b1, ticksDone % 4));
      chk("R7 R9 gated strobe", periodEnd, prevTick && ticksDone > 0 && (ticksDone % 4 == 0));
      prevTick = tick;
      @(negedge clk);
      if (prevTick) ticksDone++;
    end
    tick = 1'b0;

    // R6: stop mid sweep, then restart at zero
    @(negedge clk);
    enable = 1'b0; periodIn = 8'd5; dutyIn = 8'd2; polarity = 1'b0; centerMode = 1'b0;
    @(negedge clk);
    enable = 1'b1; tick = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    #1 chk("R6 stop level", pwmOut, 1'b0);
    @(negedge clk);
    #1 chk("R6 stop strobe", periodEnd, 1'b0);
    enable = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1 chk("R6 restart from zero", pwmOut, expLevel(5, 2, 1'b0, 1'b0, i));
      @(negedge clk);
    end
    enable = 1'b0; tick = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule